// File: doc/BRIEF.md
# Stack Adder Processor Core

This core is a small 16-bit machine whose only arithmetic source is an operand stack. Each instruction is one fixed 16-bit word that moves a word from data memory onto the stack, moves the top of the stack back to data memory, or replaces the two top entries with their sum. A halt instruction stops it. The core has no branches, so a program runs straight down the instruction memory two bytes at a time until it halts or faults.

Instructions come from an external instruction memory that the core addresses with its program counter and reads combinationally. Data lives in an internal 128-byte memory, and every operand is a 7-bit byte address. A byte-wide side port fills that memory while reset is held and reads it back at any time. The core executes one instruction per clock. It reports whether it has halted, whether a stack fault has stopped it, and how many entries the stack holds.

Top module: `stack_adder_core`

## Requirements
- R1: While reset (active-low, synchronous) is low, the program counter, the stack depth, the halted flag and the error flag are all 0 after the next clock edge.
- R2: An instruction word carries the opcode in bits [15:13] and a byte address in bits [12:6]. Opcode 000 pushes the 16-bit word whose low byte is at the address and whose high byte is at the address plus one (modulo 128), and raises the depth by one.
- R3: Opcode 001 writes the top entry to data memory, low byte at the address and high byte at the address plus one (modulo 128), then removes it. Entries leave in reverse order of arrival.
- R4: Opcode 010 removes the two top entries and pushes their sum modulo 2^16, which lowers the depth by one.
- R5: Each push, pop or add completes in one clock and advances the program counter by 2.
- R6: Opcode 111 sets the halted flag. From then on the program counter, depth and data memory stay unchanged until reset.
- R7: A pop with an empty stack, or an add with fewer than two entries, sets a sticky error flag and the halted flag. It leaves the program counter, depth and memory unchanged.
- R8: A push when the stack holds DEPTH entries sets the error flag and the halted flag, and the depth stays at DEPTH.
- R9: Opcodes 011, 100, 101 and 110 set the error flag and the halted flag without advancing the program counter.
- R10: A side-port write into data memory takes effect only while reset is low. Once reset is high, such a write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | PCW | Byte address of the current instruction |
| imem_data | input | 16 | Instruction word at imem_addr |
| mem_we | input | 1 | Side-port byte write enable (honoured only in reset) |
| mem_addr | input | 7 | Side-port byte address |
| mem_wdata | input | 8 | Side-port write byte |
| mem_rdata | output | 8 | Data memory byte at mem_addr |
| halted | output | 1 | Core has stopped |
| error | output | 1 | Sticky stack or opcode fault |
| depth | output | $clog2(DEPTH+1) | Number of stack entries |

## Verification
The bench builds the core with DEPTH=4 and PCW=8. The shallow stack means five pushes reach the full-stack fault, alongside the empty-stack and short-add faults. The 8-bit program counter matches a 128-slot instruction array held in the bench. Operands placed at address 127 exercise the wrap of the high byte to address 0, and an all-ones operand exercises the modulo-2^16 sum.

// File: rtl/stack_adder_core.sv
module stack_adder_core #(
  parameter int DEPTH = 8,
  parameter int PCW   = 8,
  localparam int SPW  = $clog2(DEPTH + 1),
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  output logic [PCW-1:0] imem_addr,
  input  logic [15:0]    imem_data,
  input  logic           mem_we,
  input  logic [6:0]     mem_addr,
  input  logic [7:0]     mem_wdata,
  output logic [7:0]     mem_rdata,
  output logic           halted,
  output logic           error,
  output logic [SPW-1:0] depth
);
  localparam logic [2:0] OP_PUSH = 3'b000;
  localparam logic [2:0] OP_POP  = 3'b001;
  localparam logic [2:0] OP_ADD  = 3'b010;
  localparam logic [2:0] OP_HALT = 3'b111;

  logic [PCW-1:0] pc_q;
  logic [SPW-1:0] sp_q;
  logic           halt_q, err_q;
  logic [7:0]     mem [128];
  logic [15:0]    stk [DEPTH];

  wire [2:0]  op  = imem_data[15:13];
  wire [6:0]  a0  = imem_data[12:6];
  wire [6:0]  a1  = a0 + 7'd1;
  wire [IW-1:0] ti = IW'(sp_q - SPW'(1));
  wire [IW-1:0] ni = IW'(sp_q - SPW'(2));
  wire [IW-1:0] pi = IW'(sp_q);
  wire [15:0] top = stk[ti];
  wire [15:0] word = {mem[a1], mem[a0]};
  wire        full = (sp_q == SPW'(DEPTH));
  wire        run  = rst_n && !halt_q;

  wire bad_op = (op != OP_PUSH) && (op != OP_POP) && (op != OP_ADD) && (op != OP_HALT);
  wire fault  = run && (bad_op || (op == OP_PUSH && full) || (op == OP_POP && sp_q == '0)
                        || (op == OP_ADD && int'(sp_q) < 2));
  wire do_push = run && !fault && op == OP_PUSH;
  wire do_pop  = run && !fault && op == OP_POP;
  wire do_add  = run && !fault && op == OP_ADD;

  assign imem_addr = pc_q;
  assign mem_rdata = mem[mem_addr];
  assign halted    = halt_q;
  assign error     = err_q;
  assign depth     = sp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q   <= '0;
      sp_q   <= '0;
      halt_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (!halt_q) begin
      if (fault) begin
        err_q  <= 1'b1;
        halt_q <= 1'b1;
      end else if (op == OP_HALT) begin
        halt_q <= 1'b1;
      end else begin
        pc_q <= pc_q + PCW'(2);
        if (do_push) sp_q <= sp_q + SPW'(1);
        else         sp_q <= sp_q - SPW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_push)     stk[pi] <= word;
    else if (do_add) stk[ni] <= top + stk[ni];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
    end else if (do_pop) begin
      mem[a0] <= top[7:0];
      mem[a1] <= top[15:8];
    end
  end

  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(sp_q) <= DEPTH); // R8
  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !halt_q |=> (halt_q || pc_q == PCW'($past(pc_q) + PCW'(2)))); // R5
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |=> (halt_q && $stable(pc_q) && $stable(sp_q))); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q); // R7
  AST_ERR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> halt_q); // R7
  AST_FAULT_HOLDS_PC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> (pc_q == $past(pc_q) && sp_q == $past(sp_q))); // R7
endmodule

// File: tb/test_stack_adder_core.sv
module test_stack_adder_core;
  localparam int DEPTH = 4;
  localparam int PCW   = 8;
  localparam int SPW   = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PCW-1:0] imem_addr;
  logic [15:0] imem_data;
  logic mem_we = 1'b0;
  logic [6:0] mem_addr = '0;
  logic [7:0] mem_wdata = '0;
  logic [7:0] mem_rdata;
  logic halted, error;
  logic [SPW-1:0] depth;
  logic [15:0] imem [128];
  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;
  assign imem_data = imem[imem_addr[PCW-1:1]];

  stack_adder_core #(.DEPTH(DEPTH), .PCW(PCW)) i_stack_adder_core (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .halted(halted), .error(error), .depth(depth));

  function automatic logic [15:0] ins(input logic [2:0] op, input logic [6:0] a);
    return {op, a, 6'b0};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [6:0] a, input logic [7:0] d);
    mem_addr = a; mem_wdata = d; mem_we = 1'b1;
    @(negedge clk);
    mem_we = 1'b0;
  endtask

  task automatic poke16(input logic [6:0] a, input logic [15:0] v);
    poke(a, v[7:0]);
    poke(a + 7'd1, v[15:8]);
  endtask

  task automatic peek16(input logic [6:0] a, output logic [15:0] v);
    mem_addr = a + 7'd1; #1; v[15:8] = mem_rdata;
    mem_addr = a;        #1; v[7:0]  = mem_rdata;
  endtask

  task automatic begin_run();
    rst_n = 1'b0; mem_we = 1'b0;
    for (int i = 0; i < 128; i++) imem[i] = ins(3'b111, 7'd0);
    @(negedge clk);
    for (int i = 0; i < 128; i++) poke(7'(i), 8'h00);
  endtask

  task automatic go();
    mem_we = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic test_reset();
    begin_run();
    chk("R1 pc", int'(imem_addr), 0);
    chk("R1 depth", int'(depth), 0);
    chk("R1 halted", int'(halted), 0);
    chk("R1 error", int'(error), 0);
  endtask

  task automatic test_basic();
    logic [15:0] v;
    begin_run();
    poke16(7'd10, 16'h1234);
    poke16(7'd20, 16'h0F0F);
    imem[0] = ins(3'b000, 7'd10);
    imem[1] = ins(3'b000, 7'd20);
    imem[2] = ins(3'b010, 7'd0);
    imem[3] = ins(3'b001, 7'd30);
    go();
    @(negedge clk); chk("R2 depth after push", int'(depth), 1); chk("R5 pc step1", int'(imem_addr), 2);
    @(negedge clk); chk("R2 depth after 2nd push", int'(depth), 2); chk("R5 pc step2", int'(imem_addr), 4);
    @(negedge clk); chk("R4 depth after add", int'(depth), 1); chk("R5 pc step3", int'(imem_addr), 6);
    @(negedge clk); chk("R3 depth after pop", int'(depth), 0);
    @(negedge clk); chk("R6 halted", int'(halted), 1); chk("R6 error clear", int'(error), 0);
    mem_addr = 7'd40; mem_wdata = 8'h55; mem_we = 1'b1;
    repeat (3) @(negedge clk);
    mem_we = 1'b0;
    chk("R6 pc frozen", int'(imem_addr), 8);
    chk("R6 depth frozen", int'(depth), 0);
    peek16(7'd30, v); chk("R4 sum stored", int'(v), 16'h2143);
    peek16(7'd40, v); chk("R10 write while running ignored", int'(v), 0);
  endtask

  task automatic test_wrap();
    logic [15:0] v;
    begin_run();
    poke(7'd127, 8'hFF);
    poke(7'd0, 8'hFF);
    poke16(7'd50, 16'h0003);
    imem[0] = ins(3'b000, 7'd127);
    imem[1] = ins(3'b000, 7'd50);
    imem[2] = ins(3'b010, 7'd0);
    imem[3] = ins(3'b001, 7'd127);
    go();
    repeat (6) @(negedge clk);
    chk("R2 wrap run halted", int'(halted), 1);
    mem_addr = 7'd127; #1; chk("R3 low byte at 127", int'(mem_rdata), 8'h02);
    mem_addr = 7'd0;   #1; chk("R3 high byte wrapped to 0", int'(mem_rdata), 8'h00);
    peek16(7'd50, v); chk("R4 source untouched", int'(v), 16'h0003);
  endtask

  task automatic test_lifo();
    logic [15:0] v;
    begin_run();
    poke16(7'd10, 16'h1111);
    poke16(7'd20, 16'h2222);
    imem[0] = ins(3'b000, 7'd10);
    imem[1] = ins(3'b000, 7'd20);
    imem[2] = ins(3'b001, 7'd60);
    imem[3] = ins(3'b001, 7'd70);
    go();
    repeat (6) @(negedge clk);
    peek16(7'd60, v); chk("R3 first pop is last push", int'(v), 16'h2222);
    peek16(7'd70, v); chk("R3 second pop is first push", int'(v), 16'h1111);
    chk("R3 depth empty", int'(depth), 0);
  endtask

  task automatic test_pop_empty();
    logic [15:0] v;
    begin_run();
    poke16(7'd5, 16'h00AB);
    imem[0] = ins(3'b001, 7'd5);
    go();
    repeat (3) @(negedge clk);
    chk("R7 pop-empty error", int'(error), 1);
    chk("R7 pop-empty halted", int'(halted), 1);
    chk("R7 pop-empty pc", int'(imem_addr), 0);
    chk("R7 pop-empty depth", int'(depth), 0);
    peek16(7'd5, v); chk("R7 pop-empty memory", int'(v), 16'h00AB);
  endtask

  task automatic test_add_short();
    begin_run();
    poke16(7'd10, 16'h0007);
    imem[0] = ins(3'b000, 7'd10);
    imem[1] = ins(3'b010, 7'd0);
    go();
    repeat (4) @(negedge clk);
    chk("R7 short-add error", int'(error), 1);
    chk("R7 short-add pc", int'(imem_addr), 2);
    chk("R7 short-add depth", int'(depth), 1);
  endtask

  task automatic test_overflow();
    begin_run();
    for (int i = 0; i <= DEPTH; i++) imem[i] = ins(3'b000, 7'd10);
    go();
    repeat (DEPTH) @(negedge clk);
    chk("R8 full no error yet", int'(error), 0);
    repeat (3) @(negedge clk);
    chk("R8 overflow error", int'(error), 1);
    chk("R8 overflow halted", int'(halted), 1);
    chk("R8 depth stays full", int'(depth), DEPTH);
    chk("R8 pc at offender", int'(imem_addr), 2 * DEPTH);
  endtask

  task automatic test_bad_op(input logic [2:0] op);
    begin_run();
    imem[0] = ins(op, 7'd3);
    go();
    repeat (3) @(negedge clk);
    chk("R9 undefined opcode error", int'(error), 1);
    chk("R9 undefined opcode halted", int'(halted), 1);
    chk("R9 undefined opcode pc", int'(imem_addr), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R5 watchdog actual=timeout expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    test_reset();
    test_basic();
    test_wrap();
    test_lifo();
    test_pop_empty();
    test_reset();
    test_add_short();
    test_overflow();
    test_bad_op(3'b011);
    test_bad_op(3'b110);
    test_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule